// File: doc/BRIEF.md
# Idle-Driven Graphics Sleep-State Controller

This block decides when a graphics unit may drop into a low-power sleep state and which depth it aims for. Each cycle it takes a set of configuration inputs (a control word made of a hardware-enable bit, a sleep-enable bit, an evaluation-window mode bit and a timeout mode bit, plus window length, busy threshold, idle hysteresis, wake limit and a software target depth) and an idle indication from the engines. It drives a sleep request, the depth code now in force and a one-cycle wake pulse.

All counting runs on a fixed time base of 1.28 us ticks. An internal divider makes these ticks from the core clock. Two automatic entry policies exist. The timeout policy sleeps once continuous idle time reaches the threshold. The evaluation-window policy measures qualified idle residency over each window and sleeps once a window closes with enough residency. A manual policy, selected by sleep-enable without hardware-enable, skips all timers and enters the software-chosen depth as soon as the unit is idle. New work always wakes the unit at once. A wake-rate limit then holds off re-entry for a programmable number of ticks.

Top module: `gpu_sleep_ctrl`

## Requirements
- R1: After reset, sleep_req is 0, cur_state is 0 and wake_req is 0.
- R2: All counts advance once per tick, and one tick lasts TICK_DIV core clock cycles.
- R3: With hw_en=1, sleep_en=1 and to_mode=1, the block enters sleep once idle_i has been high continuously for max(busy_thresh, hyst_len) ticks. It enters at depth 4 (normal).
- R4: With hw_en=1, sleep_en=1, to_mode=0 and ei_mode=1, windows of ei_len ticks start when the mode is selected. At the end of a window, sleep is entered if the count of qualified-idle ticks in that window is at least busy_thresh and idle_i is still high. Otherwise the next window is evaluated. Entry depth is 4.
- R5: No automatic decision is taken until idle_i has been high for hyst_len ticks. A tick counts as qualified idle only after that point.
- R6: With hw_en=0 and sleep_en=1, the block enters sleep on the clock edge after idle_i is high, at depth sw_target. The valid depths are 4 (normal), 5 (deep) and 6 (deepest). Any other sw_target value causes no entry.
- R7: With sleep_en=0, no entry happens. A sleeping unit returns to active on the next edge.
- R8: When idle_i falls during sleep, the unit is active on the next clock edge. wake_req is high for exactly that one cycle.
- R9: After every wake, entry is blocked for wake_limit ticks, in every mode.
- R10: cur_state is 0 while active and the entered depth code while asleep. sleep_req is high exactly while asleep.
- R11: When to_mode and ei_mode are both set, the timeout policy is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Hardware timer enable (automatic policies) |
| sleep_en | input | 1 | Sleep enable |
| ei_mode | input | 1 | Select evaluation-window policy |
| to_mode | input | 1 | Select timeout policy (has priority) |
| ei_len | input | CNT_W | Evaluation window length in ticks |
| busy_thresh | input | CNT_W | Residency threshold or idle timeout in ticks |
| hyst_len | input | CNT_W | Idle hysteresis in ticks |
| wake_limit | input | CNT_W | Re-entry hold-off after a wake, in ticks |
| sw_target | input | 3 | Software depth code for manual entry |
| idle_i | input | 1 | Engines idle |
| sleep_req | output | 1 | Unit asleep / sleep requested |
| cur_state | output | 3 | 0 when active, else depth code |
| wake_req | output | 1 | One-cycle pulse on each wake |

## Verification
A wrong hysteresis or timeout counter shows up as a sleep entry at the wrong time, several ticks away from max(busy_thresh, hyst_len). That means tens of clock cycles early or late, which the bench brackets with margins of a few cycles. A stuck window or residency register delays entry by a whole window or blocks it altogether, so the error appears one window length after it arises. Faults in wake handling show at once. If the active state is not restored on the edge after idle falls, or wake_req is not a single cycle, the fault is visible within one cycle. A dead wake-limit counter allows re-entry roughly wake_limit ticks too soon.

// File: rtl/gsc_pkg.sv
// Package: shared types and codes for the sleep-state controller.
// Assumes depth codes fit in three bits.
package gsc_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_MANUAL = 2'd1,
        MODE_TO     = 2'd2,
        MODE_EI     = 2'd3
    } gsc_mode_t;

    localparam logic [2:0] DEPTH_ACTIVE  = 3'd0;
    localparam logic [2:0] DEPTH_NORMAL  = 3'd4;
    localparam logic [2:0] DEPTH_DEEP    = 3'd5;
    localparam logic [2:0] DEPTH_DEEPEST = 3'd6;

    function automatic logic depth_valid(input logic [2:0] d);
        return (d == DEPTH_NORMAL) || (d == DEPTH_DEEP) || (d == DEPTH_DEEPEST);
    endfunction
endpackage

// File: rtl/gsc_tick_gen.sv
// Tick generator: emits a one-cycle pulse every DIV core clocks.
// This pulse is the 1.28 us time base. Assumes DIV >= 2.
module gsc_tick_gen #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    // Free-running divider with a registered pulse at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R2: a tick never lasts more than one cycle.
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/gsc_idle_eval.sv
// Idle evaluator: tracks continuous idle ticks, applies hysteresis and
// computes the automatic entry permission for the timeout and window
// policies. Assumes mode is stable during a measurement.
module gsc_idle_eval
    import gsc_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             idle_i,
    input  gsc_mode_t        mode,
    input  logic [CNT_W-1:0] ei_len,
    input  logic [CNT_W-1:0] busy_thresh,
    input  logic [CNT_W-1:0] hyst_len,
    output logic             auto_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] win_cnt;
    logic [CNT_W-1:0] res_cnt;
    logic             win_pass;
    logic             qual;
    logic             to_ok;
    logic [CNT_W:0]   res_next;

    // Continuous idle tick counter, saturating, cleared by work.
    always_ff @(posedge clk) begin
        if (!rst_n || !idle_i)
            idle_cnt <= '0;
        else if (tick && idle_cnt != CNT_MAX)
            idle_cnt <= idle_cnt + 1'b1;
    end

    // Hysteresis qualification and timeout comparison.
    always_comb begin
        qual     = idle_i && (idle_cnt >= hyst_len);
        to_ok    = qual && (idle_cnt >= busy_thresh);
        res_next = {1'b0, res_cnt} + {{CNT_W{1'b0}}, qual};
    end

    // Evaluation window: count qualified ticks, judge at window close.
    always_ff @(posedge clk) begin
        if (!rst_n || mode != MODE_EI) begin
            win_cnt  <= '0;
            res_cnt  <= '0;
            win_pass <= 1'b0;
        end else begin
            if (tick) begin
                if ({1'b0, win_cnt} + 1'b1 >= {1'b0, ei_len}) begin
                    win_cnt  <= '0;
                    res_cnt  <= '0;
                    win_pass <= idle_i && (res_next >= {1'b0, busy_thresh});
                end else begin
                    win_cnt  <= win_cnt + 1'b1;
                    res_cnt  <= res_next[CNT_W-1:0];
                end
            end
            if (!idle_i)
                win_pass <= 1'b0;
        end
    end

    // Select the permission of the active policy.
    always_comb begin
        case (mode)
            MODE_TO: auto_ok = to_ok;
            MODE_EI: auto_ok = win_pass && qual;
            default: auto_ok = 1'b0;
        endcase
    end

    // R5: automatic permission only after the hysteresis has elapsed.
    assert_hyst_before_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        auto_ok |-> (idle_i && idle_cnt >= hyst_len));
endmodule

// File: rtl/gsc_state_fsm.sv
// Sleep state machine: enters on permission, wakes on new work or on
// disable, holds off re-entry with the wake-rate limit counter.
// Assumes idle_i is synchronous to clk.
module gsc_state_fsm
    import gsc_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             idle_i,
    input  gsc_mode_t        mode,
    input  logic             auto_ok,
    input  logic [2:0]       sw_target,
    input  logic [CNT_W-1:0] wake_limit,
    output logic             sleep_req,
    output logic [2:0]       cur_state,
    output logic             wake_req
);
    logic [CNT_W-1:0] limit_cnt;
    logic             man_ok;
    logic             enter;
    logic             leave;
    logic [2:0]       depth_next;

    // Entry and exit conditions.
    always_comb begin
        man_ok     = (mode == MODE_MANUAL) && idle_i && depth_valid(sw_target);
        enter      = !sleep_req && (limit_cnt == '0) && (auto_ok || man_ok);
        leave      = sleep_req && (!idle_i || mode == MODE_OFF);
        depth_next = (mode == MODE_MANUAL) ? sw_target : DEPTH_NORMAL;
    end

    // Sleep flag, depth code and wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_req <= 1'b0;
            cur_state <= DEPTH_ACTIVE;
            wake_req  <= 1'b0;
        end else begin
            wake_req <= leave;
            if (enter) begin
                sleep_req <= 1'b1;
                cur_state <= depth_next;
            end else if (leave) begin
                sleep_req <= 1'b0;
                cur_state <= DEPTH_ACTIVE;
            end
        end
    end

    // Wake-rate limit: loaded on wake, counted down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_cnt <= '0;
        else if (leave)
            limit_cnt <= wake_limit;
        else if (tick && limit_cnt != '0)
            limit_cnt <= limit_cnt - 1'b1;
    end

    // R8: new work while asleep wakes the unit on the next edge.
    assert_wake_on_work_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !idle_i) |=> (!sleep_req && wake_req));
    // R8: the wake pulse follows an actual exit from sleep.
    assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ($past(sleep_req) && !sleep_req));
    // R9: no entry while the hold-off counter runs.
    assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_req && limit_cnt != '0) |=> !sleep_req);
    // R7: disable forces the unit active.
    assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> !sleep_req);
    // R10: state code matches sleep flag.
    assert_state_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req ? depth_valid(cur_state) : (cur_state == DEPTH_ACTIVE));
endmodule

// File: rtl/gpu_sleep_ctrl.sv
// Top: idle-driven sleep-state controller. Decodes the control bits into a
// policy and ties together tick generator, idle evaluator and state machine.
// Assumes all configuration inputs are quasi-static and synchronous.
module gpu_sleep_ctrl
    import gsc_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int TICK_DIV = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic             sleep_en,
    input  logic             ei_mode,
    input  logic             to_mode,
    input  logic [CNT_W-1:0] ei_len,
    input  logic [CNT_W-1:0] busy_thresh,
    input  logic [CNT_W-1:0] hyst_len,
    input  logic [CNT_W-1:0] wake_limit,
    input  logic [2:0]       sw_target,
    input  logic             idle_i,
    output logic             sleep_req,
    output logic [2:0]       cur_state,
    output logic             wake_req
);
    gsc_mode_t mode;
    logic      tick;
    logic      auto_ok;

    // Policy decode: timeout over window, manual when timers are off.
    always_comb begin
        if (!sleep_en)
            mode = MODE_OFF;
        else if (!hw_en)
            mode = MODE_MANUAL;
        else if (to_mode)
            mode = MODE_TO;
        else if (ei_mode)
            mode = MODE_EI;
        else
            mode = MODE_OFF;
    end

    gsc_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    gsc_idle_eval #(.CNT_W(CNT_W)) u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .idle_i     (idle_i),
        .mode       (mode),
        .ei_len     (ei_len),
        .busy_thresh(busy_thresh),
        .hyst_len   (hyst_len),
        .auto_ok    (auto_ok)
    );

    gsc_state_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .idle_i    (idle_i),
        .mode      (mode),
        .auto_ok   (auto_ok),
        .sw_target (sw_target),
        .wake_limit(wake_limit),
        .sleep_req (sleep_req),
        .cur_state (cur_state),
        .wake_req  (wake_req)
    );
endmodule

// File: tb/gpu_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module gpu_sleep_ctrl_tb;
    localparam int CNT_W = 20;
    localparam int DIV   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hw_en = 0, sleep_en = 0, ei_mode = 0, to_mode = 0;
    logic [CNT_W-1:0] ei_len = 0, busy_thresh = 0, hyst_len = 0, wake_limit = 0;
    logic [2:0]       sw_target = 0;
    logic             idle_i = 0;
    logic             sleep_req;
    logic [2:0]       cur_state;
    logic             wake_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpu_sleep_ctrl #(.CNT_W(CNT_W), .TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sleep_en(sleep_en),
        .ei_mode(ei_mode), .to_mode(to_mode), .ei_len(ei_len),
        .busy_thresh(busy_thresh), .hyst_len(hyst_len), .wake_limit(wake_limit),
        .sw_target(sw_target), .idle_i(idle_i), .sleep_req(sleep_req),
        .cur_state(cur_state), .wake_req(wake_req)
    );

    // Manual-mode table: software target and expected state code (R6).
    localparam int NVEC = 6;
    localparam int MAN_TGT [NVEC] = '{4, 5, 6, 0, 7, 3};
    localparam int MAN_EXP [NVEC] = '{4, 5, 6, 0, 0, 0};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        idle_i = 0; hw_en = 0; sleep_en = 0; ei_mode = 0; to_mode = 0;
        sw_target = 0; wake_limit = 0;
        wait_n(12 * DIV);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(4);
        chk("R1 sleep_req", sleep_req, 0);
        chk("R1 cur_state", cur_state, 0);
        chk("R1 wake_req", wake_req, 0);
        rst_n = 1;
        wait_n(4);

        // R6 table walk: manual entry depth per target code.
        for (int i = 0; i < NVEC; i++) begin
            hw_en = 0; sleep_en = 1; sw_target = 3'(MAN_TGT[i]);
            idle_i = 1;
            wait_n(2);
            chk("R6 manual depth", cur_state, MAN_EXP[i]);
            chk("R10 sleep flag", sleep_req, (MAN_EXP[i] != 0) ? 1 : 0);
            idle_i = 0;
            wait_n(1);
            chk("R8 wake active", cur_state, 0);
            chk("R8 wake pulse", wake_req, (MAN_EXP[i] != 0) ? 1 : 0);
            wait_n(1);
            chk("R8 pulse one cycle", wake_req, 0);
            wait_n(2);
        end
        quiesce();

        // R3/R2: timeout 20 ticks, hysteresis 2.
        hw_en = 1; sleep_en = 1; to_mode = 1; busy_thresh = 20; hyst_len = 2;
        idle_i = 1;
        wait_n(20 * DIV - 10);
        chk("R2 R3 no early entry", sleep_req, 0);
        wait_n(20);
        chk("R3 timeout entry", sleep_req, 1);
        chk("R3 normal depth", cur_state, 4);
        idle_i = 0;
        wait_n(1);
        chk("R8 wake after timeout", sleep_req, 0);
        chk("R8 pulse after timeout", wake_req, 1);
        quiesce();

        // R5: hysteresis 25 dominates timeout 3.
        hw_en = 1; sleep_en = 1; to_mode = 1; busy_thresh = 3; hyst_len = 25;
        idle_i = 1;
        wait_n(25 * DIV - 10);
        chk("R5 held by hysteresis", sleep_req, 0);
        wait_n(20);
        chk("R5 entry after hysteresis", sleep_req, 1);
        quiesce();

        // R4: window 20, threshold 10 passes first window.
        hw_en = 1; sleep_en = 1; ei_mode = 1; ei_len = 20; busy_thresh = 10; hyst_len = 2;
        idle_i = 1;
        wait_n(20 * DIV - 15);
        chk("R4 before window close", sleep_req, 0);
        wait_n(30);
        chk("R4 entry at window close", sleep_req, 1);
        chk("R4 depth", cur_state, 4);
        quiesce();

        // R4: threshold 19 fails first window (18 qualified), passes second.
        hw_en = 1; sleep_en = 1; ei_mode = 1; ei_len = 20; busy_thresh = 19; hyst_len = 2;
        idle_i = 1;
        wait_n(30 * DIV);
        chk("R4 first window too short", sleep_req, 0);
        wait_n(14 * DIV);
        chk("R4 second window entry", sleep_req, 1);
        quiesce();

        // R11: both mode bits, timeout used despite long window.
        hw_en = 1; sleep_en = 1; ei_mode = 1; to_mode = 1; ei_len = 1000;
        busy_thresh = 5; hyst_len = 1;
        idle_i = 1;
        wait_n(5 * DIV + 10);
        chk("R11 timeout priority", sleep_req, 1);
        quiesce();

        // R7: disabled, long idle gives no entry.
        idle_i = 1;
        wait_n(200);
        chk("R7 no entry when off", sleep_req, 0);
        chk("R7 state active", cur_state, 0);
        // R7: disabling while asleep wakes the unit.
        sleep_en = 1; sw_target = 6;
        wait_n(2);
        chk("R6 deepest entered", cur_state, 6);
        sleep_en = 0;
        wait_n(1);
        chk("R7 exit on disable", sleep_req, 0);
        quiesce();

        // R9: wake limit 10 ticks blocks manual re-entry.
        sleep_en = 1; sw_target = 5; wake_limit = 10; idle_i = 1;
        wait_n(2);
        chk("R9 first entry", sleep_req, 1);
        idle_i = 0;
        wait_n(1);
        idle_i = 1;
        wait_n(10 * DIV - 12);
        chk("R9 re-entry blocked", sleep_req, 0);
        wait_n(20);
        chk("R9 re-entry after limit", sleep_req, 1);
        chk("R10 depth after limit", cur_state, 5);
        quiesce();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule